// File: doc/BRIEF.md
# Selectable Input Qualification Filter

This block conditions one pad input before it reaches the data read path and the peripheral inputs. A two-bit mode input selects one of four treatments. The first is a two-flop synchronizer to the system clock. The second and third are stability filters that change the output only after three or six consecutive equal samples. The fourth is a purely combinational pass-through. Samples for the filters are taken at a programmable rate derived from the system clock.

The synchronizer, the sample-rate counter and the filter are cleared together in one case only: when the input clock enable is off while the pin is driven as an output. A change of mode or of direction never clears the filter. Any stale state is replaced by later samples. The filter state machine has two states. `FS_SETTLED` means the last accepted level is current and no change is pending. `FS_PENDING` means a run of samples that differ from the accepted level is being counted. The transitions are:

- *depart*: `FS_SETTLED` to `FS_PENDING`, on a sample that differs from the accepted level.
- *abandon*: `FS_PENDING` to `FS_SETTLED`, on a sample equal to the accepted level.
- *commit*: `FS_PENDING` to `FS_SETTLED`, on the sample that completes the run. The new level is accepted.

Top module: `pin_input_qualifier`

## Requirements
- R1: While reset is asserted and afterwards until new input arrives, `qual_out` is 0 in modes 00, 01 and 10. Reset clears the filter's accepted level and its run count.
- R2: With `qual_mode` = 00, `qual_out` equals `pad_in` as it was two rising clock edges earlier (two-flop synchronizer).
- R3: With `qual_mode` = 01, `qual_out` takes a new level only after 3 consecutive samples of the synchronized input show that level. With a sample every clock, the latency is 5 edges from a pad change.
- R4: With `qual_mode` = 10, 6 consecutive equal samples are needed. With a sample every clock, the latency is 8 edges from a pad change.
- R5: With `qual_mode` = 11, `qual_out` follows `pad_in` combinationally, with no clock edge involved.
- R6: A sample equal to the currently accepted level ends a pending run. A later change must then collect a full new run.
- R7: The filter samples once every 2×N clocks, where N is `sample_period`. N = 0 samples every clock. Between samples, the filtered output does not change.
- R8: When `in_clk_en` = 0 and `dir_out` = 1, the synchronizer, sample counter and filter are cleared on every edge. In modes 00 to 10, `qual_out` reads 0 after one edge.
- R9: When `in_clk_en` = 0 but `dir_out` = 0, nothing is cleared and `qual_out` keeps its value.
- R10: Changing `qual_mode` or `dir_out` does not clear the filter. The filter holds its state while the mode is 00 or 11, and resumes from that state on return to 01 or 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | 1 | Raw pad level |
| qual_mode | input | 2 | 00 sync, 01 three-sample, 10 six-sample, 11 async |
| sample_period | input | 8 | N; samples every 2×N clocks, 0 = every clock |
| in_clk_en | input | 1 | Input logic clock enable |
| dir_out | input | 1 | 1 = pin is an output |
| qual_out | output | 1 | Conditioned input level |

## Verification
The clocked assertions assume that `pad_in`, `qual_mode`, `sample_period`, `in_clk_en` and `dir_out` are stable around each rising edge. This lets the value "two edges earlier" and "the synchronized sample at the last edge" be defined exactly. On a real pad the input is asynchronous, but metastability is outside what a property can state. The stimulus therefore changes every input on the falling clock edge. Mode-change and clock-gate checks are likewise made between edges, so each comparison sees one settled configuration.

// File: rtl/pinq_pkg.sv
package pinq_pkg;

    typedef enum logic [1:0] {
        MODE_SYNC  = 2'b00,
        MODE_RUN3  = 2'b01,
        MODE_RUN6  = 2'b10,
        MODE_ASYNC = 2'b11
    } qmode_e;

    typedef enum logic {
        FS_SETTLED = 1'b0,
        FS_PENDING = 1'b1
    } fstate_e;

    localparam int SHORT_RUN = 3;
    localparam int LONG_RUN  = 6;
    localparam int RUN_W     = $clog2(LONG_RUN + 1);

    function automatic logic is_filtered(input logic [1:0] m);
        return (m == MODE_RUN3) || (m == MODE_RUN6);
    endfunction

    function automatic logic [RUN_W-1:0] run_target(input logic [1:0] m);
        return (m == MODE_RUN6) ? RUN_W'(LONG_RUN) : RUN_W'(SHORT_RUN);
    endfunction

endpackage

// File: rtl/pinq_sync.sv
module pinq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   chain_q <= '0;
                else if (clr) chain_q <= '0;
                else          chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   chain_q <= '0;
                else if (clr) chain_q <= '0;
                else          chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pinq_tick.sv
module pinq_tick #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [PER_W-1:0] period,
    output logic             tick
);
    localparam int CNT_W = PER_W + 1;

    logic [CNT_W-1:0] cnt_q, cnt_d, last_idx;

    always_comb begin
        if (period == '0) last_idx = '0;
        else              last_idx = {period, 1'b0} - CNT_W'(1);
        cnt_d = (cnt_q >= last_idx) ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else          cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == '0);
endmodule

// File: rtl/pinq_filter.sv
module pinq_filter
    import pinq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       tick,
    input  logic [1:0] mode,
    input  logic       sample,
    output logic       level
);
    fstate_e          state_q, state_d;
    logic [RUN_W-1:0] run_q, run_d, run_inc, target;
    logic             held_q, held_d;
    logic             advance;

    assign advance = tick && is_filtered(mode);
    assign target  = run_target(mode);
    assign run_inc = run_q + RUN_W'(1);

    // next-state process
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        held_d  = held_q;
        if (advance) begin
            unique case (state_q)
                FS_SETTLED: begin
                    if (sample != held_q) begin      // depart
                        state_d = FS_PENDING;
                        run_d   = RUN_W'(1);
                    end
                end
                FS_PENDING: begin
                    if (sample == held_q) begin      // abandon
                        state_d = FS_SETTLED;
                        run_d   = '0;
                    end else if (run_inc >= target) begin  // commit
                        state_d = FS_SETTLED;
                        run_d   = '0;
                        held_d  = sample;
                    end else begin
                        run_d = run_inc;
                    end
                end
                default: state_d = FS_SETTLED;
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_SETTLED;
            run_q   <= '0;
            held_q  <= 1'b0;
        end else if (clr) begin
            state_q <= FS_SETTLED;
            run_q   <= '0;
            held_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
            held_q  <= held_d;
        end
    end

    assign level = held_q;
endmodule

// File: rtl/pin_input_qualifier.sv
module pin_input_qualifier
    import pinq_pkg::*;
#(
    parameter int PER_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pad_in,
    input  logic [1:0]       qual_mode,
    input  logic [PER_W-1:0] sample_period,
    input  logic             in_clk_en,
    input  logic             dir_out,
    output logic             qual_out
);
    logic gate_clr;
    logic sync_w;
    logic tick_w;
    logic filt_w;

    assign gate_clr = !in_clk_en && dir_out;

    pinq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (gate_clr),
        .d     (pad_in),
        .q     (sync_w)
    );

    pinq_tick #(.PER_W(PER_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (gate_clr),
        .period (sample_period),
        .tick   (tick_w)
    );

    pinq_filter u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (gate_clr),
        .tick   (tick_w),
        .mode   (qual_mode),
        .sample (sync_w),
        .level  (filt_w)
    );

    // output process
    always_comb begin
        unique case (qual_mode)
            MODE_SYNC:  qual_out = sync_w;
            MODE_RUN3,
            MODE_RUN6:  qual_out = filt_w;
            MODE_ASYNC: qual_out = pad_in;
            default:    qual_out = sync_w;
        endcase
    end
endmodule

// File: rtl/pinq_checker.sv
module pinq_checker #(
    parameter int PER_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pad_in,
    input logic [1:0]       qual_mode,
    input logic [PER_W-1:0] sample_period,
    input logic             in_clk_en,
    input logic             dir_out,
    input logic             qual_out,
    input logic             sample_tick,
    input logic             sync_q
);
    logic [1:0] age_q;
    logic       gate;
    logic       filt_mode;

    assign gate      = !in_clk_en && dir_out;
    assign filt_mode = (qual_mode == 2'b01) || (qual_mode == 2'b10);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    AST_ASYNC_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_mode == 2'b11) |-> (qual_out == pad_in));  // R5

    AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && qual_mode == 2'b00 && !$past(gate) && !$past(gate, 2))
        |-> (qual_out == $past(pad_in, 2)));  // R2

    AST_GATE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && $past(gate) && qual_mode != 2'b11) |-> (qual_out == 1'b0));  // R8

    AST_HOLD_BETWEEN_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && filt_mode && qual_mode == $past(qual_mode)
         && !$past(sample_tick) && !$past(gate))
        |-> (qual_out == $past(qual_out)));  // R7

    AST_COMMIT_FROM_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && filt_mode && qual_mode == $past(qual_mode)
         && !$past(gate) && qual_out != $past(qual_out))
        |-> (qual_out == $past(sync_q)));  // R3

    AST_EVERY_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && $past(sample_period) == '0) |-> sample_tick);  // R7

endmodule

bind pin_input_qualifier pinq_checker #(.PER_W(PER_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pad_in        (pad_in),
    .qual_mode     (qual_mode),
    .sample_period (sample_period),
    .in_clk_en     (in_clk_en),
    .dir_out       (dir_out),
    .qual_out      (qual_out),
    .sample_tick   (tick_w),
    .sync_q        (sync_w)
);

// File: tb/pin_input_qualifier_bench.sv
`timescale 1ns/1ps
module pin_input_qualifier_bench;
    localparam time HALF = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pad_in = 1'b0;
    logic [1:0] qual_mode = 2'b00;
    logic [7:0] sample_period = 8'd0;
    logic       in_clk_en = 1'b1;
    logic       dir_out = 1'b0;
    logic       qual_out;

    int total = 0;
    int bad = 0;

    always #HALF clk = ~clk;

    pin_input_qualifier u_pin_input_qualifier (
        .clk           (clk),
        .rst_n         (rst_n),
        .pad_in        (pad_in),
        .qual_mode     (qual_mode),
        .sample_period (sample_period),
        .in_clk_en     (in_clk_en),
        .dir_out       (dir_out),
        .qual_out      (qual_out)
    );

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: qual_out=%b expected=%b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic restart(input logic [1:0] m, input logic [7:0] n);
        @(negedge clk);
        rst_n = 1'b0; pad_in = 1'b0; qual_mode = m; sample_period = n;
        in_clk_en = 1'b1; dir_out = 1'b0;
        edges(2);
        rst_n = 1'b1;
        edges(1);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0; pad_in = 1'b1; qual_mode = 2'b01;
        edges(1);
        check("R1 in reset", qual_out, 1'b0);
        restart(2'b00, 8'd0);
        check("R1 after reset", qual_out, 1'b0);
    endtask

    task automatic t_sync;
        restart(2'b00, 8'd0);
        pad_in = 1'b1;
        edges(1);
        check("R2 one edge", qual_out, 1'b0);
        edges(1);
        check("R2 two edges", qual_out, 1'b1);
        pad_in = 1'b0;
        edges(2);
        check("R2 fall", qual_out, 1'b0);
    endtask

    task automatic t_run3;
        restart(2'b01, 8'd0);
        pad_in = 1'b1;
        edges(4);
        check("R3 edge4", qual_out, 1'b0);
        edges(1);
        check("R3 edge5", qual_out, 1'b1);
        pad_in = 1'b0;
        edges(2);
        pad_in = 1'b1;
        edges(6);
        check("R3 two-sample dip ignored", qual_out, 1'b1);
    endtask

    task automatic t_run6;
        restart(2'b10, 8'd0);
        pad_in = 1'b1;
        edges(7);
        check("R4 edge7", qual_out, 1'b0);
        edges(1);
        check("R4 edge8", qual_out, 1'b1);
    endtask

    task automatic t_restart;
        restart(2'b10, 8'd0);
        pad_in = 1'b1; edges(5);
        pad_in = 1'b0; edges(1);
        pad_in = 1'b1; edges(5);
        pad_in = 1'b0; edges(10);
        check("R6 broken runs", qual_out, 1'b0);
        pad_in = 1'b1; edges(8);
        check("R6 full run", qual_out, 1'b1);
    endtask

    task automatic t_async;
        restart(2'b11, 8'd5);
        pad_in = 1'b1; #1;
        check("R5 rise", qual_out, 1'b1);
        pad_in = 1'b0; #1;
        check("R5 fall", qual_out, 1'b0);
        in_clk_en = 1'b0; dir_out = 1'b1; pad_in = 1'b1; edges(2);
        check("R5 under gate", qual_out, 1'b1);
    endtask

    task automatic t_period;
        restart(2'b01, 8'd2);
        pad_in = 1'b1;
        edges(10);
        check("R7 N=2 early", qual_out, 1'b0);
        edges(4);
        check("R7 N=2 late", qual_out, 1'b1);
        restart(2'b01, 8'd1);
        pad_in = 1'b1;
        edges(6);
        check("R7 N=1 early", qual_out, 1'b0);
        edges(2);
        check("R7 N=1 late", qual_out, 1'b1);
    endtask

    task automatic t_gate;
        restart(2'b01, 8'd0);
        pad_in = 1'b1; edges(6);
        check("R8 setup", qual_out, 1'b1);
        in_clk_en = 1'b0; dir_out = 1'b0; edges(3);
        check("R9 input pin no clear", qual_out, 1'b1);
        dir_out = 1'b1; edges(1);
        check("R8 cleared", qual_out, 1'b0);
        in_clk_en = 1'b1; edges(4);
        check("R8 refill edge4", qual_out, 1'b0);
        edges(1);
        check("R8 refill edge5", qual_out, 1'b1);
        qual_mode = 2'b00; in_clk_en = 1'b0; edges(1);
        check("R8 sync cleared", qual_out, 1'b0);
    endtask

    task automatic t_mode_change;
        restart(2'b01, 8'd0);
        pad_in = 1'b1; edges(6);
        pad_in = 1'b0; qual_mode = 2'b00; edges(3);
        check("R10 sync view", qual_out, 1'b0);
        qual_mode = 2'b01; #1;
        check("R10 level kept", qual_out, 1'b1);
        dir_out = 1'b1; edges(2);
        check("R10 dir flip, mid run", qual_out, 1'b1);
        edges(1);
        check("R10 resumed run", qual_out, 1'b0);
    endtask

    initial begin
        #(HALF * 2 * 200000);
        bad++; total++;
        $display("FAIL watchdog: run hung");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_sync();
        t_run3();
        t_run6();
        t_restart();
        t_async();
        t_period();
        t_gate();
        t_mode_change();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule